// File: doc/BRIEF.md
# Serial EEPROM Slave Command Controller

This block is the slave side of a serial memory holding 512 bytes. A host drives chip select, a serial clock and a data input in SPI mode 0 and receives data on a tri-stateable output. It also drives an active-low pause input and an active-low hardware write-protect input. Each frame opens with an instruction byte that selects one of six operations: array read, array write, status read, status write, write enable and write disable. The block sets or clears a write-enable latch. It runs a timed internal write cycle and commits the byte or status value when the cycle ends.

All serial inputs are sampled by the system clock, and serial clock edges are found from the sampled level. The byte store is a register array. A parameterised count of system clocks models the programming time. The host sees that time through the write-in-progress bit of the status byte.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset, and whenever chip select is high, `miso_oe_o` is low. A status read after reset returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch, which is status bit 1, and opcode 0x04 clears it. Bits that follow either opcode in the same frame are ignored.
- R3: Opcode 0000_A011 starts a read, where A is address bit 8. The next byte gives address bits 7..0. Data is returned MSB first, and the first bit is valid before the first clock rise after the address byte. The address then increments once per byte and wraps from 0x1FF to 0x000.
- R4: Opcode 0000_A010, the address byte and one data byte start a write cycle if the latch is set. During the cycle status bit 0 reads 1 for `WR_CYCLES` system clocks. The byte is then stored and the latch is clear.
- R5: A write frame sent while the latch is clear changes no stored byte.
- R6: While `wp_n_i` is low the latch is held clear and opcode 0x06 cannot set it. A low level at any point before the last data bit means no write cycle starts. Reads and status reads still work while it is low.
- R7: A write cycle that has started completes and commits even if `wp_n_i` goes low during it.
- R8: While status bit 0 is 1, every opcode except status read (0x05) is ignored for the rest of its frame.
- R9: An opcode outside the defined set makes the block ignore the rest of the frame. It does not drive the output and changes no state.
- R10: With chip select low, a fall of `hold_n_i` while the serial clock is low pauses the frame. During the pause clock edges are ignored and `miso_oe_o` is low. A rise of `hold_n_i` while the clock is low resumes the frame where it stopped.
- R11: Raising chip select during a pause resets the frame. After reselection the block stays paused, ignoring clock edges, until `hold_n_i` rises.
- R12: Opcode 0x01 followed by a data byte, with the latch set, starts a write cycle. After the cycle, status bits 7..2 hold data bits 7..2 and the latch is clear. Without the latch the frame does nothing.
- R13: Bit 3 of an opcode is ignored for all non-array instructions. For example, 0x0E acts as 0x06 and 0x0C acts as 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling all serial inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, mode 0 |
| mosi_i | input | 1 | Serial data in, MSB first |
| hold_n_i | input | 1 | Active-low pause request |
| wp_n_i | input | 1 | Active-low hardware write protect |
| miso_o | output | 1 | Serial data out, MSB first |
| miso_oe_o | output | 1 | Drive enable for `miso_o` |

## Verification
The assertions assume that all serial inputs are synchronous to the system clock. They also assume each serial clock level lasts at least two system clocks, so every edge of the serial clock is seen exactly once. The pause checks further assume that `hold_n_i` changes only while the serial clock is low. The bench changes inputs only on falling system clock edges and holds each serial clock level for three system clocks. It moves the hold and write-protect pins only while the serial clock is low.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_SROUT, ST_SRIN, ST_IDLE
  } ee_state_e;

  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_MASK  = 8'hF7; // bit 3 is address or don't-care
endpackage

// File: rtl/ee_edge_det.sv
module ee_edge_det #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/ee_hold_ctrl.sv
module ee_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic held_o
);
  logic h_rise, h_fall;

  ee_edge_det #(.RST_VAL(1'b1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (hold_n_i),
    .rise_o (h_rise),
    .fall_o (h_fall)
  );

  // entry needs selection; exit does not, so a pause survives deselect
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          held_o <= 1'b0;
    else if (h_fall && !sck_i && !cs_n_i) held_o <= 1'b1;
    else if (h_rise && !sck_i)            held_o <= 1'b0;
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end

  assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import ee_spi_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_n_i,
  input  logic wp_n_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  ee_state_e         state_q;
  logic [BIT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, out_q, shin, op_na, status, rdata, pend_data_q;
  logic [BYTE_W-3:0] sr_user_q;
  logic [ADDR_W-1:0] rd_addr_q, pend_addr_q, new_addr, raddr;
  logic sck_q, held, shift_en, byte_end, data_end, start_wr, wr_done, mem_we;
  logic wel_q, wip, a8_q, is_rd_q, pend_sr_q, cmd_wren, cmd_wrdi;
  ee_state_e cmd_next;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;

  ee_hold_ctrl u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (cs_n_i),
    .sck_i    (sck_i),
    .hold_n_i (hold_n_i),
    .held_o   (held)
  );

  assign shift_en = ~cs_n_i & ~held & sck_i & ~sck_q;
  assign byte_end = shift_en && (cnt_q == LAST_BIT);
  assign shin     = {sh_q[BYTE_W-2:0], mosi_i};
  assign op_na    = shin & OP_MASK;
  assign status   = {sr_user_q, wel_q, wip};
  assign new_addr = ADDR_W'({a8_q, shin});
  assign raddr    = (state_q == ST_ADDR) ? new_addr : rd_addr_q;
  assign data_end = byte_end && (state_q == ST_WDATA || state_q == ST_SRIN);
  assign start_wr = data_end & wel_q & wp_n_i;
  assign mem_we   = wr_done & ~pend_sr_q;

  always_comb begin
    cmd_next = ST_IDLE;
    cmd_wren = 1'b0;
    cmd_wrdi = 1'b0;
    if (!wip || op_na == OP_RDSR) begin
      case (op_na)
        OP_WREN:           cmd_wren = 1'b1;
        OP_WRDI:           cmd_wrdi = 1'b1;
        OP_RDSR:           cmd_next = ST_SROUT;
        OP_WRSR:           cmd_next = ST_SRIN;
        OP_READ, OP_WRITE: cmd_next = ST_ADDR;
        default:           cmd_next = ST_IDLE;
      endcase
    end
  end

  ee_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wr),
    .busy_o  (wip),
    .done_o  (wr_done)
  );

  ee_byte_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (pend_addr_q),
    .wdata_i (pend_data_q),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cnt_q <= '0;
      sh_q <= '0;
      out_q <= '0;
      a8_q <= 1'b0;
      is_rd_q <= 1'b0;
      rd_addr_q <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_sr_q <= 1'b0;
      sr_user_q <= '0;
    end else begin
      if (wr_done && pend_sr_q) sr_user_q <= pend_data_q[BYTE_W-1:2];
      if (start_wr) begin
        pend_data_q <= shin;
        pend_sr_q   <= (state_q == ST_SRIN);
      end
      if (cs_n_i) begin
        state_q <= ST_CMD;
        cnt_q   <= '0;
      end else if (shift_en) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= shin;
        unique case (state_q)
          ST_CMD: if (byte_end) begin
            state_q <= cmd_next;
            a8_q    <= shin[3];
            is_rd_q <= (op_na == OP_READ);
            out_q   <= status;
          end
          ST_ADDR: if (byte_end) begin
            if (is_rd_q) begin
              state_q   <= ST_RDATA;
              out_q     <= rdata;
              rd_addr_q <= new_addr + 1'b1;
            end else begin
              state_q     <= ST_WDATA;
              pend_addr_q <= new_addr;
            end
          end
          ST_WDATA, ST_SRIN: if (byte_end) state_q <= ST_IDLE;
          ST_RDATA: begin
            if (byte_end) begin
              out_q     <= rdata;
              rd_addr_q <= rd_addr_q + 1'b1;
            end else begin
              out_q <= out_q << 1;
            end
          end
          ST_SROUT: out_q <= byte_end ? status : (out_q << 1);
          ST_IDLE: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                          wel_q <= 1'b0;
    else if (!wp_n_i)                                     wel_q <= 1'b0;
    else if (byte_end && state_q == ST_CMD && cmd_wren)   wel_q <= 1'b1;
    else if ((byte_end && state_q == ST_CMD && cmd_wrdi) || data_end)
                                                          wel_q <= 1'b0;

  assign miso_oe_o = ~cs_n_i & ~held & (state_q == ST_RDATA || state_q == ST_SROUT);
  assign miso_o    = miso_oe_o & out_q[BYTE_W-1];
endmodule

// File: rtl/ee_spi_checker.sv
module ee_spi_checker #(
  parameter int ADDR_W    = 9,
  parameter int WR_CYCLES = 2000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_i,
  input logic       wp_n_i,
  input logic       miso_oe_o,
  input logic       held_i,
  input logic       wel_i,
  input logic       wip_i,
  input logic       mem_we_i,
  input logic [2:0] cnt_i
);
  logic [31:0] wip_len_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    wip_len_q <= '0;
    else if (wip_i) wip_len_q <= wip_len_q + 1;
    else            wip_len_q <= '0;

  p_no_oe_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !miso_oe_o);

  p_wip_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |-> (wip_len_q < 32'(WR_CYCLES)));

  p_wip_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> (wip_len_q == 32'(WR_CYCLES)));

  p_wel_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_n_i |=> !wel_i);

  p_commit_in_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> wip_i);

  p_hold_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && !cs_n_i) |=> $stable(cnt_i));

  p_hold_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i |-> !miso_oe_o);
endmodule

bind spi_eeprom_ctrl ee_spi_checker #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_n_i    (cs_n_i),
  .wp_n_i    (wp_n_i),
  .miso_oe_o (miso_oe_o),
  .held_i    (held),
  .wel_i     (wel_q),
  .wip_i     (wip),
  .mem_we_i  (mem_we),
  .cnt_i     (cnt_q)
);

// File: tb/spi_eeprom_ctrl_bench.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl_bench;
  localparam int WRC = 500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic miso, oe;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] exp_mem [512];

  always #2 clk = ~clk;

  spi_eeprom_ctrl #(.ADDR_W(9), .WR_CYCLES(WRC)) u_spi_eeprom_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_n_i(hold_n), .wp_n_i(wp_n), .miso_o(miso), .miso_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();   cs_n = 1'b0; idle(3); endtask
  task automatic desel(); cs_n = 1'b1; idle(3); endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_any, output logic oe_all);
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      idle(2);
      rx[i] = miso;
      oe_any |= oe;
      oe_all &= oe;
      sck = 1'b1;
      idle(3);
      sck = 1'b0;
    end
    idle(1);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; logic a, b;
    xfer(tx, rx, a, b);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); send(op); desel();
  endtask

  task automatic rd_sr(output logic [7:0] sr);
    logic a, b;
    sel(); send(8'h05); xfer(8'h00, sr, a, b); desel();
  endtask

  task automatic wr_byte(input logic [8:0] a, input logic [7:0] d);
    sel(); send({4'b0, a[8], 3'b010}); send(a[7:0]); send(d); desel();
  endtask

  task automatic rd_byte(input logic [8:0] a, output logic [7:0] d, output logic oe_ok);
    logic x;
    sel(); send({4'b0, a[8], 3'b011}); send(a[7:0]); xfer(8'h00, d, x, oe_ok); desel();
  endtask

  task automatic wait_wip();
    logic [7:0] sr;
    for (int k = 0; k < 40; k++) begin
      rd_sr(sr);
      if (!sr[0]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] sr, d, rx;
    logic ok, any, all;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    chk("R1 oe after reset", oe, 1'b0);
    rd_sr(sr);
    chk("R1 status after reset", sr, 8'h00);

    // R2: latch set/clear, trailing bits ignored
    cmd1(8'h06); rd_sr(sr); chk("R2 wren", sr, 8'h02);
    cmd1(8'h04); rd_sr(sr); chk("R2 wrdi", sr, 8'h00);
    sel(); send(8'h06); send(8'h04); desel(); rd_sr(sr);
    chk("R2 bits after wren ignored", sr, 8'h02);
    // R13: bit 3 don't-care on non-array opcodes
    cmd1(8'h0C); rd_sr(sr); chk("R13 wrdi with bit3", sr, 8'h00);
    cmd1(8'h0E); rd_sr(sr); chk("R13 wren with bit3", sr, 8'h02);
    cmd1(8'h04);

    // R5: write without latch
    wr_byte(9'h105, 8'hAA);
    rd_sr(sr); chk("R5 no cycle started", sr, 8'h00);
    rd_byte(9'h105, d, ok); chk("R5 byte unchanged", d, 8'h00);

    // R4: sweep of writes across both address halves
    for (int i = 0; i < 32; i++) begin
      logic [8:0] a;
      logic [7:0] v;
      a = 9'((i * 37 + 5) % 512);
      v = 8'((a * 5 + i) & 8'hFF);
      cmd1(8'h06);
      wr_byte(a, v);
      exp_mem[a] = v;
      if (i == 0) begin
        rd_sr(sr); chk("R4 wip set, latch clear", sr, 8'h01);
      end
      wait_wip();
      rd_byte(a, d, ok);
      chk("R4 readback", d, v);
    end
    rd_sr(sr); chk("R4 final status", sr, 8'h00);

    // R3: full sequential read from 0 and wrap 0x1FE..0x001
    sel(); send(8'h03); send(8'h00);
    for (int i = 0; i < 512; i++) begin
      xfer(8'h00, rx, any, all);
      if (rx !== exp_mem[i] || !all) chk("R3 sequential read", {23'b0, all, rx}, {24'h1, exp_mem[i]});
    end
    desel();
    chk("R3 sequential pass", 1'b1, 1'b1);
    sel(); send(8'h0B); send(8'hFE);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, rx, any, all);
      chk("R3 wrap read", rx, exp_mem[(510 + i) % 512]);
    end
    desel();

    // R6: protect pin
    wp_n = 1'b0; idle(2);
    cmd1(8'h06); rd_sr(sr); chk("R6 wren blocked while wp low", sr, 8'h00);
    rd_byte(9'h005, d, ok);
    chk("R6 read while wp low", {ok, d}, {1'b1, exp_mem[5]});
    wp_n = 1'b1; idle(2);
    cmd1(8'h06);
    sel(); send(8'h02); send(8'h05);
    for (int i = 7; i >= 0; i--) begin
      mosi = i[0]; idle(2);
      if (i == 4) wp_n = 1'b0;
      if (i == 2) wp_n = 1'b1;
      sck = 1'b1; idle(3); sck = 1'b0;
    end
    idle(1); desel();
    rd_sr(sr); chk("R6 wp pulse blocks write", sr, 8'h00);
    rd_byte(9'h005, d, ok); chk("R6 byte kept", d, exp_mem[5]);

    // R7: wp low after start does not abort
    cmd1(8'h06);
    wr_byte(9'h1F0, 8'h3C);
    exp_mem[9'h1F0] = 8'h3C;
    wp_n = 1'b0; idle(2);
    wait_wip();
    wp_n = 1'b1; idle(2);
    rd_byte(9'h1F0, d, ok); chk("R7 committed despite wp", d, 8'h3C);

    // R8: only status read accepted during cycle
    cmd1(8'h06);
    wr_byte(9'h011, 8'h77);
    exp_mem[9'h011] = 8'h77;
    cmd1(8'h06);
    sel(); send(8'h03); send(8'h11); xfer(8'h00, rx, any, all); desel();
    chk("R8 read rejected during wip", any, 1'b0);
    rd_sr(sr); chk("R8 status during wip", sr, 8'h01);
    wait_wip();
    rd_sr(sr); chk("R8 wren rejected during wip", sr, 8'h00);
    rd_byte(9'h011, d, ok); chk("R8 write completed", d, 8'h77);

    // R9: invalid opcodes
    sel(); send(8'hFF); xfer(8'h06, rx, any, all); desel();
    chk("R9 no drive after 0xFF", any, 1'b0);
    sel(); send(8'h13); send(8'h06); desel();
    rd_sr(sr); chk("R9 no state change", sr, 8'h00);

    // R10: pause mid read
    sel(); send(8'h03); send(8'h11);
    xfer(8'h00, rx, any, all);
    chk("R10 byte before pause", rx, exp_mem[9'h011]);
    hold_n = 1'b0; idle(3);
    chk("R10 oe low in pause", oe, 1'b0);
    for (int i = 0; i < 5; i++) begin
      mosi = i[0]; idle(2); sck = 1'b1; idle(3); sck = 1'b0;
    end
    idle(1);
    chk("R10 oe still low", oe, 1'b0);
    hold_n = 1'b1; idle(3);
    xfer(8'h00, rx, any, all);
    chk("R10 resumed byte", {all, rx}, {1'b1, exp_mem[9'h012]});
    desel();

    // R11: deselect during pause resets frame; pause persists
    sel(); send(8'h06); desel();
    sel(); send(8'h04); desel(); // latch clear
    sel();
    for (int i = 7; i >= 4; i--) begin
      mosi = 1'b0; idle(2); sck = 1'b1; idle(3); sck = 1'b0;
    end
    idle(1);
    hold_n = 1'b0; idle(3);
    cs_n = 1'b1; idle(3);
    cs_n = 1'b0; idle(3);
    send(8'h06);                // must be ignored while paused
    hold_n = 1'b1; idle(3);
    desel();
    rd_sr(sr); chk("R11 paused bits ignored", sr, 8'h00);
    sel();
    for (int i = 7; i >= 4; i--) begin
      mosi = 1'b0; idle(2); sck = 1'b1; idle(3); sck = 1'b0;
    end
    idle(1);
    hold_n = 1'b0; idle(3);
    cs_n = 1'b1; idle(3);
    cs_n = 1'b0; idle(3);
    hold_n = 1'b1; idle(3);
    send(8'h06);
    desel();
    rd_sr(sr); chk("R11 frame restarted", sr, 8'h02);
    cmd1(8'h04);

    // R12: status write
    sel(); send(8'h01); send(8'h54); desel();
    rd_sr(sr); chk("R12 wrsr without latch", sr, 8'h00);
    cmd1(8'h06);
    sel(); send(8'h01); send(8'hAB); desel();
    wait_wip();
    rd_sr(sr); chk("R12 status written", sr, 8'hA8);

    // R1: output released when deselected
    chk("R1 oe when deselected", oe, 1'b0);

    finish_run();
  end
endmodule